// File: doc/BRIEF.md
# Hold-Request Conversion Scheduler

This block arbitrates sampling requests from three channel pairs (A, B and C) that share one dual converter. Each pair has an active-low hold line. A falling edge on a hold line asks for a conversion of that pair. Requests wait in a short queue and are served one pair at a time. While a conversion runs, the block drives an active-low busy output. It counts out the conversion cycle in clock periods.

When a conversion reaches its latch point, the block samples the two 12-bit results from a stand-in converter port. It then emits them with the pair identifier as a one-cycle result beat. The beat is a valid-only stream with no ready: the downstream output buffer must take every beat in the cycle it appears, so there is no back-pressure. Pair identifiers are A = 0, B = 1 and C = 2.

Between its request and its latched result, a pair counts as held. While a pair is held, further edges on its line are discarded. Reset drops the running conversion, the queue and all held state.

Top module: `hold_sched`

## Requirements
- R1: While reset is asserted, and at its release, `busy_n` is 1, `res_valid` is 0 and nothing is queued.
- R2: A request is a high-to-low transition of a `hold_n` bit seen between two consecutive rising clock edges (bit 0 = A, bit 1 = B, bit 2 = C). A line that stays low produces no further request. A line that is already low when reset is released is not a request until it has gone high and fallen again.
- R3: With the converter idle, a request accepted at clock edge k starts a conversion at edge k+1. `busy_n` then stays low for exactly 13 clock cycles.
- R4: `res_valid` pulses for exactly one cycle, in the cycle in which `busy_n` returns high. It carries `res_data0`/`res_data1` equal to `sar_res0`/`sar_res1` as sampled at the clock edge that ends the last busy cycle.
- R5: Requests accepted at the same clock edge are converted in the order A, then B, then C. Each is reported with its identifier on `res_pair`.
- R6: A request accepted while a conversion runs is queued. The next conversion starts 16 clock cycles after the start of the current one, so successive busy falling edges are at least 16 cycles apart.
- R7: Edges on the line of a pair that is queued or converting are ignored until that pair's result beat has been produced.
- R8: Reset during a conversion cancels it and every queued request. No result beat appears for them, and `busy_n` stays high after release until a new request arrives.
- R9: `conv_pair` holds the identifier of the pair being converted and does not change while `busy_n` is low. `res_pair` equals it in the result beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_n | input | 3 | Active-low hold requests, bit 0 = A, 1 = B, 2 = C |
| sar_res0 | input | 12 | Stand-in converter result, first channel of the pair |
| sar_res1 | input | 12 | Stand-in converter result, second channel of the pair |
| busy_n | output | 1 | Low while a conversion runs up to its latch point |
| conv_pair | output | 2 | Identifier of the pair currently converting |
| res_valid | output | 1 | One-cycle result beat |
| res_pair | output | 2 | Pair identifier of the result beat |
| res_data0 | output | 12 | Latched first result |
| res_data1 | output | 12 | Latched second result |

## Verification
The assertions assume that `hold_n` changes only away from the rising clock edge. They also assume that the converter results are stable at the latch edge. The stimulus meets both conditions by changing inputs a few nanoseconds after each rising edge. The random phase drops lines with a low probability and releases them with a higher one. It also inserts an occasional reset. This mix produces simultaneous edges, edges during busy, lines held low for long stretches, and cancellations.

// File: rtl/hold_sched_pkg.sv
package hold_sched_pkg;
  localparam int NPAIR = 3;
  localparam int ID_W  = 2;
  typedef logic [ID_W-1:0] pair_t;
  localparam pair_t PAIR_A = 2'd0;
  localparam pair_t PAIR_B = 2'd1;
  localparam pair_t PAIR_C = 2'd2;
endpackage

// File: rtl/hold_edge_track.sv
module hold_edge_track
  import hold_sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAIR-1:0] hold_n,
  input  logic             clr_en,
  input  pair_t            clr_pair,
  output logic [NPAIR-1:0] accept
);
  logic [NPAIR-1:0] prev_q;
  logic [NPAIR-1:0] held_q;

  // prev resets low so a line already low at release is not a request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= hold_n;
  end

  genvar g;
  generate
    for (g = 0; g < NPAIR; g++) begin : g_pair
      assign accept[g] = prev_q[g] & ~hold_n[g] & ~held_q[g];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               held_q[g] <= 1'b0;
        else if (accept[g])                       held_q[g] <= 1'b1;
        else if (clr_en && clr_pair == pair_t'(g)) held_q[g] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/hold_queue.sv
module hold_queue
  import hold_sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAIR-1:0] push_vec,
  input  logic             pop,
  output pair_t            head,
  output logic             not_empty
);
  localparam int CW = $clog2(NPAIR + 1);

  pair_t          q_q [NPAIR];
  pair_t          q_d [NPAIR];
  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  cnt_d;

  always_comb begin
    int n;
    for (int j = 0; j < NPAIR; j++) q_d[j] = q_q[j];
    n = int'(cnt_q);
    if (pop && n != 0) begin
      for (int j = 0; j < NPAIR - 1; j++) q_d[j] = q_q[j+1];
      n = n - 1;
    end
    // lower index wins: A, then B, then C
    for (int i = 0; i < NPAIR; i++) begin
      if (push_vec[i] && n < NPAIR) begin
        q_d[n] = pair_t'(i);
        n = n + 1;
      end
    end
    cnt_d = CW'(n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int j = 0; j < NPAIR; j++) q_q[j] <= PAIR_A;
    end else begin
      cnt_q <= cnt_d;
      for (int j = 0; j < NPAIR; j++) q_q[j] <= q_d[j];
    end
  end

  assign head      = q_q[0];
  assign not_empty = (cnt_q != '0);
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import hold_sched_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int CYCLE_LEN = 16,
  parameter int LATCH_CYC = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_not_empty,
  input  pair_t             q_head,
  input  logic [DATA_W-1:0] sar0,
  input  logic [DATA_W-1:0] sar1,
  output logic              pop,
  output logic              busy_n,
  output pair_t             conv_pair,
  output logic              res_valid,
  output pair_t             res_pair,
  output logic [DATA_W-1:0] res_d0,
  output logic [DATA_W-1:0] res_d1,
  output logic              clr_en,
  output pair_t             clr_pair
);
  localparam int CNT_W = $clog2(CYCLE_LEN);

  logic             run_q;
  logic [CNT_W-1:0] k_q;
  pair_t            pair_q;
  logic             last_cyc;
  logic             latch_now;

  assign last_cyc  = run_q && (k_q == CNT_W'(CYCLE_LEN - 1));
  assign latch_now = run_q && (k_q == CNT_W'(LATCH_CYC - 1));
  assign pop       = q_not_empty && (!run_q || last_cyc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      k_q    <= '0;
      pair_q <= PAIR_A;
    end else if (pop) begin
      run_q  <= 1'b1;
      k_q    <= '0;
      pair_q <= q_head;
    end else if (last_cyc) begin
      run_q  <= 1'b0;
      k_q    <= '0;
    end else if (run_q) begin
      k_q    <= k_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_pair  <= PAIR_A;
      res_d0    <= '0;
      res_d1    <= '0;
    end else begin
      res_valid <= latch_now;
      if (latch_now) begin
        res_pair <= pair_q;
        res_d0   <= sar0;
        res_d1   <= sar1;
      end
    end
  end

  assign busy_n    = !(run_q && (k_q < CNT_W'(LATCH_CYC)));
  assign conv_pair = pair_q;
  assign clr_en    = latch_now;
  assign clr_pair  = pair_q;
endmodule

// File: rtl/hold_sched.sv
module hold_sched
  import hold_sched_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int CYCLE_LEN = 16,
  parameter int LATCH_CYC = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        hold_n,
  input  logic [DATA_W-1:0] sar_res0,
  input  logic [DATA_W-1:0] sar_res1,
  output logic              busy_n,
  output logic [1:0]        conv_pair,
  output logic              res_valid,
  output logic [1:0]        res_pair,
  output logic [DATA_W-1:0] res_data0,
  output logic [DATA_W-1:0] res_data1
);
  logic [NPAIR-1:0] accept;
  logic             clr_en;
  pair_t            clr_pair;
  logic             pop;
  pair_t            head;
  logic             not_empty;

  hold_edge_track u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_n   (hold_n),
    .clr_en   (clr_en),
    .clr_pair (clr_pair),
    .accept   (accept)
  );

  hold_queue u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_vec  (accept),
    .pop       (pop),
    .head      (head),
    .not_empty (not_empty)
  );

  conv_sequencer #(
    .DATA_W    (DATA_W),
    .CYCLE_LEN (CYCLE_LEN),
    .LATCH_CYC (LATCH_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .q_not_empty (not_empty),
    .q_head      (head),
    .sar0        (sar_res0),
    .sar1        (sar_res1),
    .pop         (pop),
    .busy_n      (busy_n),
    .conv_pair   (conv_pair),
    .res_valid   (res_valid),
    .res_pair    (res_pair),
    .res_d0      (res_data0),
    .res_d1      (res_data1),
    .clr_en      (clr_en),
    .clr_pair    (clr_pair)
  );
endmodule

// File: rtl/hold_sched_chk.sv
module hold_sched_chk #(
  parameter int CYCLE_LEN = 16,
  parameter int LATCH_CYC = 13
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_n,
  input logic [1:0] conv_pair,
  input logic       res_valid,
  input logic [1:0] res_pair
);
  localparam int RW = $clog2(CYCLE_LEN + 2);

  logic [RW-1:0] low_run;
  logic [RW-1:0] since_start;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run     <= '0;
      since_start <= RW'(CYCLE_LEN);
      busy_q      <= 1'b1;
    end else begin
      busy_q  <= busy_n;
      low_run <= busy_n ? '0 : low_run + 1'b1;
      if (busy_q && !busy_n)                   since_start <= '0;
      else if (since_start < RW'(CYCLE_LEN))   since_start <= since_start + 1'b1;
    end
  end

  assert_busy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> (low_run < RW'(LATCH_CYC)));
  assert_busy_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && !busy_q) |-> (low_run == RW'(LATCH_CYC)));
  assert_single_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  assert_beat_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (busy_n && !busy_q));
  assert_start_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !busy_n) |-> (since_start >= RW'(CYCLE_LEN - 1)));
  assert_pair_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && !busy_q) |-> $stable(conv_pair));
  assert_beat_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_pair == conv_pair));
endmodule

bind hold_sched hold_sched_chk #(
  .CYCLE_LEN (CYCLE_LEN),
  .LATCH_CYC (LATCH_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_n    (busy_n),
  .conv_pair (conv_pair),
  .res_valid (res_valid),
  .res_pair  (res_pair)
);

// File: tb/tb_hold_sched.sv
`timescale 1ns/1ps
module tb_hold_sched;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    hold_n = 3'b111;
  logic [DW-1:0] sar_res0 = '0;
  logic [DW-1:0] sar_res1 = '0;
  logic          busy_n;
  logic [1:0]    conv_pair;
  logic          res_valid;
  logic [1:0]    res_pair;
  logic [DW-1:0] res_data0;
  logic [DW-1:0] res_data1;

  hold_sched dut (
    .clk(clk), .rst_n(rst_n), .hold_n(hold_n),
    .sar_res0(sar_res0), .sar_res1(sar_res1),
    .busy_n(busy_n), .conv_pair(conv_pair),
    .res_valid(res_valid), .res_pair(res_pair),
    .res_data0(res_data0), .res_data1(res_data1)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model built from the requirements ----------
  logic [2:0]    m_prev, m_held;
  int            m_q [3];
  int            m_qn;
  bit            m_run;
  int            m_k;
  int            m_pair;
  bit            m_ev;
  int            m_ep;
  logic [DW-1:0] m_e0, m_e1;

  task automatic model_reset();
    m_prev = 3'b000; m_held = 3'b000; m_qn = 0;
    m_run = 0; m_k = 0; m_pair = 0; m_ev = 0; m_ep = 0; m_e0 = '0; m_e1 = '0;
  endtask

  task automatic model_step();
    logic [2:0] acc;
    bit last;
    acc = m_prev & ~hold_n & ~m_held;
    m_prev = hold_n;
    m_ev = m_run && (m_k == 12);
    if (m_ev) begin
      m_ep = m_pair; m_e0 = sar_res0; m_e1 = sar_res1;
      m_held[m_pair] = 1'b0;
    end
    last = m_run && (m_k == 15);
    if (m_qn > 0 && (!m_run || last)) begin
      m_pair = m_q[0];
      m_q[0] = m_q[1]; m_q[1] = m_q[2];
      m_qn--;
      m_run = 1; m_k = 0;
    end else if (last) begin
      m_run = 0; m_k = 0;
    end else if (m_run) begin
      m_k++;
    end
    for (int i = 0; i < 3; i++) begin
      if (acc[i]) begin
        m_q[m_qn] = i; m_qn++;
        m_held[i] = 1'b1;
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  // ---------------- monitor at the falling edge --------------------------
  int  cyc = 0;
  bit  prev_busy = 1;
  int  last_fall = -100;
  int  gap = 0;
  int  low_len = 0;
  int  last_low_len = 0;
  int  vcnt [3];
  int  vlog [16];
  int  nlog = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(busy_n == !(m_run && m_k < 13), "R3 busy_n", busy_n, !(m_run && m_k < 13));
      chk(res_valid == m_ev, "R4 res_valid", res_valid, m_ev);
      if (m_ev) begin
        chk(res_pair == m_ep[1:0], "R5 res_pair order", res_pair, m_ep);
        chk(res_data0 == m_e0, "R4 res_data0", res_data0, m_e0);
        chk(res_data1 == m_e1, "R4 res_data1", res_data1, m_e1);
      end
      if (m_run) chk(conv_pair == m_pair[1:0], "R9 conv_pair", conv_pair, m_pair);
      if (prev_busy && !busy_n) begin
        gap = cyc - last_fall; last_fall = cyc;
      end
      if (!busy_n) low_len++;
      else if (!prev_busy) begin last_low_len = low_len; low_len = 0; end
      if (res_valid) begin
        vcnt[res_pair]++;
        if (nlog < 16) begin vlog[nlog] = res_pair; nlog++; end
      end
      prev_busy = busy_n;
    end else begin
      prev_busy = 1; low_len = 0;
    end
  end

  // ---------------- stimulus helpers -------------------------------------
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      sar_res0 = DW'($urandom); sar_res1 = DW'($urandom);
    end
  endtask

  task automatic set_hold(input logic [2:0] v);
    @(posedge clk); #2;
    hold_n = v;
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 0; hold_n = 3'b111;
    @(negedge clk);
    chk(busy_n == 1, "R1 busy_n in reset", busy_n, 1);
    chk(res_valid == 0, "R1 res_valid in reset", res_valid, 0);
    step(2);
    rst_n = 1;
    step(2);
  endtask

  task automatic clear_counts();
    vcnt[0] = 0; vcnt[1] = 0; vcnt[2] = 0; nlog = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_7864));
    vcnt[0] = 0; vcnt[1] = 0; vcnt[2] = 0;
    step(3);
    @(negedge clk);
    chk(busy_n == 1 && res_valid == 0, "R1 reset outputs", {busy_n, res_valid}, 2);
    rst_n = 1;
    step(3);
    @(negedge clk);
    chk(busy_n == 1, "R1 idle after release", busy_n, 1);

    // R3 / R4: single request on B
    clear_counts();
    set_hold(3'b101);
    step(30);
    chk(last_low_len == 13, "R3 busy low length", last_low_len, 13);
    chk(vcnt[1] == 1, "R4 one beat for B", vcnt[1], 1);

    // R5: all three fall together
    set_hold(3'b111); step(3);
    clear_counts();
    set_hold(3'b000);
    step(60);
    chk(nlog == 3, "R5 beat count", nlog, 3);
    chk(vlog[0] == 0 && vlog[1] == 1 && vlog[2] == 2, "R5 order A,B,C",
        vlog[0] * 100 + vlog[1] * 10 + vlog[2], 12);

    // R2: lines kept low create no more requests
    clear_counts();
    step(50);
    chk(nlog == 0, "R2 held-low lines stay silent", nlog, 0);

    // R2: low through reset release is not a request
    @(posedge clk); #2; rst_n = 0; hold_n = 3'b110;
    step(2); rst_n = 1;
    clear_counts();
    step(30);
    chk(nlog == 0, "R2 low at release ignored", nlog, 0);

    // R7: repeated A edges while A is pending/converting
    set_hold(3'b111); step(3);
    clear_counts();
    set_hold(3'b110);
    step(3);
    for (int t = 0; t < 4; t++) begin
      set_hold(3'b111); set_hold(3'b110);
    end
    set_hold(3'b111);
    step(40);
    chk(vcnt[0] == 1, "R7 extra A edges ignored", vcnt[0], 1);

    // R6: C requested while A converts
    clear_counts();
    set_hold(3'b110);
    step(4);
    set_hold(3'b010);
    step(40);
    chk(gap == 16, "R6 start spacing", gap, 16);
    chk(nlog == 2 && vlog[1] == 2, "R6 queued C served", nlog, 2);
    set_hold(3'b111); step(3);

    // R8: reset mid-conversion with a queued request
    clear_counts();
    set_hold(3'b101);
    step(2);
    set_hold(3'b100);
    step(5);
    do_reset();
    set_hold(3'b111);
    step(40);
    chk(nlog == 0, "R8 no beats after cancel", nlog, 0);
    chk(busy_n == 1, "R8 busy_n idle", busy_n, 1);

    // random phase
    for (int s = 0; s < 4000; s++) begin
      logic [2:0] h;
      h = hold_n;
      for (int i = 0; i < 3; i++) begin
        if (h[i]) begin if (($urandom % 8) == 0) h[i] = 1'b0; end
        else      begin if (($urandom % 3) == 0) h[i] = 1'b1; end
      end
      if (($urandom % 500) == 0) do_reset();
      set_hold(h);
    end
    step(40);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule